// File: doc/BRIEF.md
# Serial ADC Acquisition Adapter

This block sits between control logic clocked at 50 MHz and an external 8-bit successive-approximation converter whose result leaves the chip one bit at a time. The controller sees a plain parallel interface. It raises a sample strobe, and a fixed time later it receives an interrupt pulse with the new 8-bit result already on the data bus.

Each acquisition starts on the rising edge of the strobe. The adapter first pulls the converter's active-low convert line low and holds it for the 4 us the conversion needs. It then toggles a serial clock, made by dividing the system clock, and shifts in eight bits, most significant first. When the fixed 5.4 us window has run out, it moves the assembled word onto the bus and pulses the interrupt for one cycle. That window caps the rate at about 185 ksamples/s.

All durations are parameters given in nanoseconds. They are turned into clock counts from the clock frequency in MHz. With the defaults, conversion is 200 cycles, the full window is 270 cycles, and each serial bit takes 8 cycles.

Top module: `adc_acq_top`

## Requirements
- R1: While `rst` is high on a clock edge, the block returns to idle. After that edge `irq_o` is 0, `adc_conv_n_o` is 1, `adc_sclk_o` is 0 and `data_o` is 0.
- R2: A rising edge on `sample_i` seen while idle drives `adc_conv_n_o` low from the next clock edge. A strobe level that is already high while `rst` is asserted is not treated as an edge.
- R3: `adc_conv_n_o` stays low for exactly 200 system clock cycles (4000 ns at 50 MHz) per acquisition.
- R4: After the convert line returns high, `adc_sclk_o` produces exactly 8 rising edges. Each half period lasts 4 clock cycles. `adc_sclk_o` stays low whenever `adc_conv_n_o` is low.
- R5: The bit on `adc_sdata_i` is captured at each rising edge of `adc_sclk_o`. The first captured bit becomes `data_o[7]` and the last becomes `data_o[0]`.
- R6: `irq_o` is high for exactly one cycle, 270 cycles (5400 ns) after the edge that accepted the strobe. `data_o` carries the new result in that same cycle.
- R7: `data_o` holds its value at every cycle other than a completion, including during the next acquisition up to its interrupt.
- R8: A rising edge on `sample_i` while an acquisition is in progress is ignored. A strobe that is simply held high never starts another acquisition.
- R9: Asserting `rst` during an acquisition abandons it. No interrupt follows, and the block afterwards starts only on a fresh strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Acquisition strobe; rising edge starts a conversion |
| adc_sdata_i | input | 1 | Serial result bit from the converter |
| adc_conv_n_o | output | 1 | Active-low convert-start line to the converter |
| adc_sclk_o | output | 1 | Serial read clock to the converter |
| data_o | output | 8 | Parallel result, held until the next completion |
| irq_o | output | 1 | One-cycle pulse marking a new result |

## Verification
A wrong window counter or state shows up at once as an interrupt at some count other than 270, or as a convert-low interval other than 200 cycles. Both are measured per acquisition with single-cycle resolution. A wrong shift phase or bit counter shows up within the same acquisition, as a serial-clock count other than eight or a result that does not match the word the converter model sent. Every one of the 256 codes is swept, so a bit-order or stuck-bit fault cannot hide. A busy flag that clears early shows up as an extra convert-low interval or a second interrupt within a few cycles of the ignored strobe edge.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

    typedef enum logic [1:0] {
        ACQ_IDLE = 2'd0,
        ACQ_CONV = 2'd1,
        ACQ_READ = 2'd2,
        ACQ_HOLD = 2'd3
    } acq_state_e;

    // Whole clock cycles covering a duration given in nanoseconds.
    function automatic int unsigned ns_to_cycles(input int unsigned clk_mhz,
                                                 input int unsigned dur_ns);
        return (clk_mhz * dur_ns) / 1000;
    endfunction

    // Width of a counter that must reach limit-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/adc_acq_edge.sv
module adc_acq_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    // Reset value 1: a level already high across reset is not an edge.
    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/adc_acq_shift.sv
module adc_acq_shift #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned SCLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              sdata_i,
    output logic              sclk_o,
    output logic              done_o,
    output logic [DATA_W-1:0] word_o
);
    import adc_acq_pkg::*;

    localparam int unsigned DIV_W = cnt_width(2 * SCLK_HALF);
    localparam int unsigned BIT_W = cnt_width(DATA_W);
    localparam logic [DIV_W-1:0] DIV_MID  = DIV_W'(SCLK_HALF - 1);
    localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(2 * SCLK_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic              sclk_q;
    logic [DATA_W-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            bit_q   <= '0;
            sclk_q  <= 1'b0;
            shreg_q <= '0;
        end else if (!run_i) begin
            div_q  <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
        end else begin
            div_q <= (div_q == DIV_END) ? '0 : div_q + 1'b1;
            if (div_q == DIV_MID) begin
                sclk_q  <= 1'b1;
                shreg_q <= {shreg_q[DATA_W-2:0], sdata_i};
            end
            if (div_q == DIV_END) begin
                sclk_q <= 1'b0;
                bit_q  <= bit_q + 1'b1;
            end
        end
    end

    assign sclk_o = sclk_q;
    assign done_o = run_i && (div_q == DIV_END) && (bit_q == BIT_LAST);
    assign word_o = shreg_q;
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CONV_CYC = 200,
    parameter int unsigned WIN_CYC  = 270
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rd_done_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              run_o,
    output logic              conv_n_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] data_o
);
    import adc_acq_pkg::*;

    localparam int unsigned CNT_W = cnt_width(WIN_CYC);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 1);

    acq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              conv_n_q;
    logic              irq_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ACQ_IDLE;
            cnt_q    <= '0;
            conv_n_q <= 1'b1;
            irq_q    <= 1'b0;
            data_q   <= '0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ACQ_IDLE: begin
                    if (start_i) begin
                        state_q  <= ACQ_CONV;
                        cnt_q    <= '0;
                        conv_n_q <= 1'b0;
                    end
                end
                ACQ_CONV: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CONV_LAST) begin
                        state_q  <= ACQ_READ;
                        conv_n_q <= 1'b1;
                    end
                end
                ACQ_READ: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (rd_done_i) state_q <= ACQ_HOLD;
                end
                ACQ_HOLD: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == WIN_LAST) begin
                        state_q <= ACQ_IDLE;
                        irq_q   <= 1'b1;
                        data_q  <= word_i;
                    end
                end
                default: state_q <= ACQ_IDLE;
            endcase
        end
    end

    assign run_o    = (state_q == ACQ_READ);
    assign conv_n_o = conv_n_q;
    assign irq_o    = irq_q;
    assign data_o   = data_q;
endmodule

// File: rtl/adc_acq_top.sv
module adc_acq_top #(
    parameter int unsigned CLK_MHZ   = 50,
    parameter int unsigned CONV_NS   = 4000,
    parameter int unsigned WINDOW_NS = 5400,
    parameter int unsigned SCLK_HALF = 4,
    parameter int unsigned DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_i,
    input  logic              adc_sdata_i,
    output logic              adc_conv_n_o,
    output logic              adc_sclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic              irq_o
);
    import adc_acq_pkg::*;

    localparam int unsigned CONV_CYC = ns_to_cycles(CLK_MHZ, CONV_NS);
    localparam int unsigned WIN_CYC  = ns_to_cycles(CLK_MHZ, WINDOW_NS);

    logic              start_w;
    logic              run_w;
    logic              done_w;
    logic [DATA_W-1:0] word_w;

    adc_acq_edge edge_i (
        .clk     (clk),
        .rst     (rst),
        .level_i (sample_i),
        .rise_o  (start_w)
    );

    adc_acq_shift #(
        .DATA_W    (DATA_W),
        .SCLK_HALF (SCLK_HALF)
    ) shift_i (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run_w),
        .sdata_i (adc_sdata_i),
        .sclk_o  (adc_sclk_o),
        .done_o  (done_w),
        .word_o  (word_w)
    );

    adc_acq_ctrl #(
        .DATA_W   (DATA_W),
        .CONV_CYC (CONV_CYC),
        .WIN_CYC  (WIN_CYC)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_w),
        .rd_done_i (done_w),
        .word_i    (word_w),
        .run_o     (run_w),
        .conv_n_o  (adc_conv_n_o),
        .irq_o     (irq_o),
        .data_o    (data_o)
    );
endmodule

// File: rtl/adc_acq_chk.sv
module adc_acq_chk #(
    parameter int unsigned CONV_CYC = 200,
    parameter int unsigned DATA_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_i,
    input logic              adc_conv_n_o,
    input logic              adc_sclk_o,
    input logic              irq_o,
    input logic [DATA_W-1:0] data_o
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)               low_cnt <= '0;
        else if (!adc_conv_n_o) low_cnt <= low_cnt + 1'b1;
        else                   low_cnt <= '0;
    end

    p_conv_from_edge_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_conv_n_o) |-> ($past(sample_i) && !$past(sample_i, 2)));

    p_conv_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_conv_n_o) |-> (low_cnt == 16'(CONV_CYC)));

    p_sclk_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !adc_conv_n_o |-> !adc_sclk_o);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    p_irq_idle_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (adc_conv_n_o && !adc_sclk_o));

    p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> $stable(data_o));
endmodule

bind adc_acq_top adc_acq_chk #(
    .CONV_CYC (CONV_CYC),
    .DATA_W   (DATA_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .sample_i     (sample_i),
    .adc_conv_n_o (adc_conv_n_o),
    .adc_sclk_o   (adc_sclk_o),
    .irq_o        (irq_o),
    .data_o       (data_o)
);

// File: tb/adc_acq_top_tb_top.sv
module adc_acq_top_tb_top;
    localparam int CONV = 50 * 4000 / 1000;
    localparam int WIN  = 50 * 5400 / 1000;
    localparam int NBIT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample = 1'b0;
    logic       sdata = 1'b0;
    logic       conv_n;
    logic       sclk;
    logic [7:0] data;
    logic       irq;

    logic [7:0] adc_word = 8'h00;
    int         sclk_rises = 0;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    adc_acq_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .sample_i     (sample),
        .adc_sdata_i  (sdata),
        .adc_conv_n_o (conv_n),
        .adc_sclk_o   (sclk),
        .data_o       (data),
        .irq_o        (irq)
    );

    // Converter model: first bit after conversion, next bit on each falling serial clock.
    initial begin
        int  idx;
        logic prev_conv;
        logic prev_sclk;
        idx = NBIT;
        prev_conv = 1'b1;
        prev_sclk = 1'b0;
        forever begin
            @(conv_n or sclk);
            if (conv_n === 1'b1 && prev_conv === 1'b0) idx = 0;
            else if (sclk === 1'b0 && prev_sclk === 1'b1) idx++;
            prev_conv = conv_n;
            prev_sclk = sclk;
            sdata = (idx < NBIT) ? adc_word[NBIT-1-idx] : 1'b0;
        end
    end

    initial begin
        forever begin
            @(posedge sclk);
            sclk_rises++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic acquire(input logic [7:0] w, input bit glitch);
        int conv_low;
        int irq_hi;
        int first;
        int data_at;
        bit hold_ok;
        bit conv_at0;
        logic [7:0] prev;
        adc_word = w;
        prev = data;
        sclk_rises = 0;
        conv_low = 0;
        irq_hi = 0;
        first = -1;
        data_at = -1;
        hold_ok = 1'b1;
        conv_at0 = 1'b0;
        @(negedge clk);
        check(conv_n === 1'b1, "R2 idle before strobe", int'(conv_n), 1);
        sample = 1'b1;
        @(posedge clk);
        for (int j = 0; j < WIN + 4; j++) begin
            @(negedge clk);
            if (j == 0) conv_at0 = (conv_n === 1'b0);
            if (conv_n === 1'b0) conv_low++;
            if (irq === 1'b1) begin
                irq_hi++;
                if (first < 0) begin
                    first = j;
                    data_at = int'(data);
                end
            end else if (first < 0 && data !== prev) begin
                hold_ok = 1'b0;
            end
            if (glitch && j == 40) sample = 1'b0;
            if (glitch && j == 41) sample = 1'b1;
        end
        check(conv_at0, "R2 convert low after edge", int'(conv_at0), 1);
        check(conv_low == CONV, "R3 convert low cycles", conv_low, CONV);
        check(sclk_rises == NBIT, "R4 serial clock edges", sclk_rises, NBIT);
        check(data_at == int'(w), "R5 captured word", data_at, int'(w));
        check(first == WIN, "R6 interrupt latency", first, WIN);
        check(irq_hi == 1, "R6 interrupt width", irq_hi, 1);
        check(hold_ok, "R7 data held before completion", int'(hold_ok), 1);
        if (glitch) begin
            check(conv_low == CONV && irq_hi == 1, "R8 busy edge ignored", conv_low, CONV);
        end
        @(negedge clk);
        sample = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int quiet;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(irq === 1'b0, "R1 reset irq", int'(irq), 0);
        check(conv_n === 1'b1, "R1 reset convert line", int'(conv_n), 1);
        check(sclk === 1'b0, "R1 reset serial clock", int'(sclk), 0);
        check(data === 8'h00, "R1 reset data", int'(data), 0);

        for (int w = 0; w < 256; w++) begin
            acquire(8'(w), (w % 5) == 0);
        end

        // R9: reset in the middle of a conversion, strobe held high across it.
        adc_word = 8'hA5;
        @(negedge clk);
        sample = 1'b1;
        repeat (100) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(conv_n === 1'b1, "R9 convert line after reset", int'(conv_n), 1);
        check(irq === 1'b0, "R9 irq after reset", int'(irq), 0);
        check(data === 8'h00, "R9 data after reset", int'(data), 0);
        quiet = 1;
        for (int j = 0; j < WIN + 20; j++) begin
            @(negedge clk);
            if (irq !== 1'b0 || conv_n !== 1'b1) quiet = 0;
        end
        check(quiet == 1, "R8 held strobe never restarts", quiet, 1);
        sample = 1'b0;
        repeat (3) @(negedge clk);
        acquire(8'h3C, 1'b0);
        acquire(8'hC3, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule